// File: doc/BRIEF.md
# I2C Register-Write Target

This block is the bus-facing front end of a register-mapped peripheral that a host programs over a two-wire serial bus. It runs on a fast system clock and treats the clock and data lines as plain inputs. It passes both lines through a flop synchronizer, watches for their edges, and recognises the start and stop conditions. It then checks the 7-bit target address against its own address. That address has five fixed upper bits, and its lowest two bits come from strap pins.

When a write is addressed to it, the block acknowledges the address byte. It loads the next byte into an 8-bit register pointer. Every byte after that is issued on a one-cycle write strobe together with the current pointer, and the pointer then steps forward by one. A frame may carry any number of data bytes. Frames with another address, and read requests, get no acknowledge, and the block stays silent until the next start or stop. The data line is driven open-drain: the output only asks for the line to be pulled low during an acknowledge bit.

Top module: `i2c_wr_target`

## Requirements
- R1: While reset is held and directly after it, `sda_pull` is 0 and `wr_stb` is 0.
- R2: The target address is {0b01000, strap[1], strap[0]}; strap[0] is address bit 0. A byte with that address and R/W (the last bit, sent last) = 0 is acknowledged: `sda_pull` is 1 while SCL is high in the ninth clock. With strap = 01 the address 0x21 is matched.
- R3: A byte with any other address is not acknowledged, and later bytes in that frame are neither acknowledged nor strobed.
- R4: A matched address with R/W = 1 is not acknowledged, and the frame produces no strobe.
- R5: The byte after an acknowledged address sets the pointer and is acknowledged. Each following byte is taken MSB first, acknowledged, and issued with `wr_addr` = pointer and `wr_data` = the byte.
- R6: Each accepted data byte raises `wr_stb` for exactly one clock.
- R7: The pointer goes up by one after each strobed byte and wraps from 0xFF to 0x00.
- R8: `sda_pull` changes only while the synchronized SCL is low, and it is 0 again after the falling edge of the acknowledge clock.
- R9: A repeated START inside a frame, with no STOP before it, restarts address matching. This holds even when the frame before it was being ignored.
- R10: A STOP in the middle of a byte drops the partial byte with no strobe, and the next frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 2 | Low two bits of the target address |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 8 | Register address for the strobe |
| wr_data | output | 8 | Data byte for the strobe |

## Verification
The assertions assume a well-behaved bus host. It changes SDA only while SCL is low, except when it makes a start or stop. It never makes a start or stop while the target is holding SDA low, and it keeps the straps steady within a frame.

The bench host drives every data bit a quarter bit-time after SCL falls. It raises SCL only once the data has settled, and it makes its start and stop edges only after it has released SDA. Random frames mix matching and non-matching addresses, read requests, pointer values near the wrap point, and burst lengths from one to five bytes.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [4:0]  FIXED_HI = 5'b01000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_PTR,
        S_DATA,
        S_ACK,
        S_IGNORE
    } state_t;

    // Synchronized line levels and the bus events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] strap);
        return a == {FIXED_HI, strap};
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[STAGES-1];
        ev.sda      = sda_sh[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_d;
        ev.scl_fall = ~ev.scl & scl_d;
        ev.start    = ev.scl & scl_d & sda_d & ~ev.sda;
        ev.stop     = ev.scl & scl_d & ~sda_d & ev.sda;
    end

endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap,
    output logic              drv,
    output logic              stb,
    output logic [BYTE_W-1:0] waddr,
    output logic [BYTE_W-1:0] wdata
);

    localparam logic [3:0] FULL = 4'(BYTE_W);

    state_t            state;
    state_t            ret;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            ret   <= S_IDLE;
            cnt   <= '0;
            sh    <= '0;
            ptr   <= '0;
            drv   <= 1'b0;
            stb   <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else begin
            stb <= 1'b0;
            if (ev.stop) begin
                state <= S_IDLE;
                drv   <= 1'b0;
            end else if (ev.start) begin
                state <= S_ADDR;
                cnt   <= '0;
                drv   <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_PTR, S_DATA: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            case (state)
                                S_ADDR: begin
                                    if (addr_hit(sh[7:1], strap) && !sh[0]) begin
                                        drv   <= 1'b1;
                                        state <= S_ACK;
                                        ret   <= S_PTR;
                                    end else begin
                                        state <= S_IGNORE;
                                    end
                                end
                                S_PTR: begin
                                    ptr   <= sh;
                                    drv   <= 1'b1;
                                    state <= S_ACK;
                                    ret   <= S_DATA;
                                end
                                default: begin
                                    stb   <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= sh;
                                    ptr   <= ptr + 8'd1;
                                    drv   <= 1'b1;
                                    state <= S_ACK;
                                    ret   <= S_DATA;
                                end
                            endcase
                        end
                    end
                    S_ACK: begin
                        if (ev.scl_fall) begin
                            drv   <= 1'b0;
                            state <= ret;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the pull-down moves only while synchronized SCL is low
    a_r8_drv_scl_low: assert property (@(posedge clk) disable iff (rst)
        (drv != $past(drv)) |-> !ev.scl);

    // R6: a strobe never lasts two cycles
    a_r6_stb_single: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    // R7: pointer is one past the address just strobed
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
        stb |-> ptr == waddr + 8'd1);

    // R3: no pull-down while the frame is being ignored
    a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IGNORE) |-> !drv && !stb);

    // R5: strobes come only out of the data phase
    a_r5_stb_from_data: assert property (@(posedge clk) disable iff (rst)
        stb |-> $past(state) == S_DATA);

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_strap,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    bus_ev_t ev;

    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cw_engine u_eng (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .strap (addr_strap),
        .drv   (sda_pull),
        .stb   (wr_stb),
        .waddr (wr_addr),
        .wdata (wr_data)
    );

    // R1: released and quiet in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !sda_pull && !wr_stb);

endmodule

// File: tb/i2c_wr_target_tb.sv
module i2c_wr_target_tb;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_pull;
    logic       wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       sda_bus;

    int tests = 0;
    int fails = 0;

    logic [7:0] log_addr [0:511];
    logic [7:0] log_data [0:511];
    int         log_n = 0;
    int         dbl = 0;
    logic       prev_stb = 1'b0;
    logic [7:0] fdata [0:7];

    assign sda_bus = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    i2c_wr_target u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_strap (strap),
        .sda_pull   (sda_pull),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            log_addr[log_n % 512] = wr_addr;
            log_data[log_n % 512] = wr_data;
            log_n = log_n + 1;
            if (prev_stb) dbl = dbl + 1;
        end
        prev_stb = wr_stb;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_bus;
        wq();
        scl_m = 1'b0; wq();
        rel = ~sda_pull;
    endtask

    function automatic bit exp_match(input logic [6:0] a, input logic [1:0] s, input bit rw);
        return (a == {5'b01000, s}) && !rw;
    endfunction

    // One frame: address byte, pointer byte, n data bytes from fdata
    task automatic frame(input logic [1:0] s, input logic [6:0] a, input bit rw,
                         input logic [7:0] p, input int n, input bit with_stop);
        int   base;
        bit   acc;
        logic ack, rel;
        strap = s;
        base  = log_n;
        acc   = exp_match(a, s, rw);
        bus_start();
        send_byte({a, rw}, ack, rel);
        chk(ack == acc, "R2/R3/R4 address ack", 32'(ack), 32'(acc));
        chk(rel, "R8 release after ack", 32'(rel), 32'd1);
        send_byte(p, ack, rel);
        chk(ack == acc, "R5 pointer ack", 32'(ack), 32'(acc));
        for (int k = 0; k < n; k++) begin
            send_byte(fdata[k], ack, rel);
            chk(ack == acc, "R5 data ack", 32'(ack), 32'(acc));
            chk(rel, "R8 release after data ack", 32'(rel), 32'd1);
        end
        if (with_stop) bus_stop();
        chk((log_n - base) == (acc ? n : 0), "R3/R4/R5 strobe count", 32'(log_n - base), 32'(acc ? n : 0));
        if (acc) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] ea;
                ea = p + 8'(k);
                chk(log_addr[(base + k) % 512] == ea, "R5/R7 wr_addr", 32'(log_addr[(base + k) % 512]), 32'(ea));
                chk(log_data[(base + k) % 512] == fdata[k], "R5 wr_data", 32'(log_data[(base + k) % 512]), 32'(fdata[k]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int   base;
        logic ack, rel;
        void'($urandom(32'h5eed_1c2a));
        repeat (4) @(negedge clk);
        // R1: quiet during reset
        chk(!sda_pull && !wr_stb, "R1 during reset", 32'({sda_pull, wr_stb}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sda_pull && !wr_stb, "R1 after reset", 32'({sda_pull, wr_stb}), 32'd0);
        wq();

        // R2/R5: strap 01 -> address 0x21
        fdata[0] = 8'hA5; fdata[1] = 8'h3C;
        frame(2'b01, 7'h21, 1'b0, 8'h10, 2, 1'b1);
        // R3: mismatched address
        frame(2'b01, 7'h22, 1'b0, 8'h10, 2, 1'b1);
        // R4: read request to own address
        frame(2'b01, 7'h21, 1'b1, 8'h10, 1, 1'b1);
        // R7: wrap
        fdata[0] = 8'h5A; fdata[1] = 8'hC3; fdata[2] = 8'h0F;
        frame(2'b10, 7'h22, 1'b0, 8'hFF, 3, 1'b1);
        // R9: ignored frame, then repeated start to a matched one, no stop between
        frame(2'b11, 7'h20, 1'b0, 8'h40, 1, 1'b0);
        fdata[0] = 8'h77;
        frame(2'b11, 7'h23, 1'b0, 8'h40, 1, 1'b0);
        fdata[0] = 8'h99;
        frame(2'b11, 7'h23, 1'b0, 8'h50, 1, 1'b1);

        // R10: stop mid-byte drops the partial byte
        strap = 2'b00;
        base  = log_n;
        bus_start();
        send_byte({7'h20, 1'b0}, ack, rel);
        send_byte(8'h30, ack, rel);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk(log_n == base, "R10 no strobe on partial byte", 32'(log_n - base), 32'd0);
        chk(!sda_pull, "R10 line released", 32'(sda_pull), 32'd0);
        fdata[0] = 8'hE1;
        frame(2'b00, 7'h20, 1'b0, 8'h31, 1, 1'b1);

        // Random frames
        for (int f = 0; f < 25; f++) begin
            logic [1:0] s;
            logic [6:0] a;
            bit         rw;
            logic [7:0] p;
            int         n;
            s  = 2'($urandom_range(0, 3));
            a  = ($urandom_range(0, 9) < 7) ? {5'b01000, s} : 7'($urandom_range(0, 127));
            rw = ($urandom_range(0, 9) == 0);
            p  = ($urandom_range(0, 3) == 0) ? 8'hFE : 8'($urandom_range(0, 255));
            n  = $urandom_range(1, 5);
            for (int k = 0; k < n; k++) fdata[k] = 8'($urandom_range(0, 255));
            frame(s, a, rw, p, n, 1'b1);
        end

        // R6: no strobe seen high on two consecutive cycles
        chk(dbl == 0, "R6 single-cycle strobe", 32'(dbl), 32'd0);
        chk(!sda_pull, "R8 released at end", 32'(sda_pull), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule